// File: doc/BRIEF.md
# Single-Line Read Cache with Staleness Timeout

This block sits between one read requester and a shared memory controller. It keeps one wide line together with the line address it came from. A read whose address falls inside that line is served straight from the line while the line is still fresh. Any other read sends one line fetch to the memory side. When the line comes back, the block stores it and returns the requested lane. The lane is picked by the low address bits.

Freshness is set by parameters. With the timeout enabled, a down-counter is reloaded on every accepted read and counts controller clock cycles. When it runs out, the line is no longer trusted, even if a later address matches it. A reload value of zero turns caching off completely. With the timeout disabled, the line stays usable until an address outside it is requested. The counter runs on the block's own clock, whatever the requester's pace.

Top module: `rd_line_cache`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. The line is marked empty, so the first accepted read always causes a line fetch.
- R2: A read that is not a hit raises `mem_req_valid` with `mem_req_addr` equal to `req_addr >> OFF_W`. Both stay unchanged until a cycle in which `mem_req_ready` is 1.
- R3: Only one fetch is in flight at a time. `req_ready` is 0 from the cycle after a missing read is accepted until the cycle after `mem_rsp_valid` delivers the line.
- R4: On the cycle `mem_rsp_valid` is 1, the line is stored. In the next cycle `rsp_valid` pulses, with `rsp_data = mem_rsp_data[off*LANE_W +: LANE_W]`, where `off = req_addr[OFF_W-1:0]` of the missing read.
- R5: A hit raises `rsp_valid` exactly one cycle after acceptance, with `rsp_data = line[off*LANE_W +: LANE_W]`, and issues no fetch. A hit is an accepted read whose `req_addr >> OFF_W` equals the stored line address while the line is valid and fresh. Lane 0 is bits [LANE_W-1:0].
- R6: With `TOUT_EN=1` and `TOUT_CYC=N>0`, a read accepted k cycles after the previous accepted read can hit only if k <= N. For k > N it is fetched again even when its line address matches.
- R7: With `TOUT_EN=1` and `TOUT_CYC=0`, every accepted read causes a fetch.
- R8: With `TOUT_EN=0`, the stored line stays usable however long the gap between reads. Only a read of a different line address causes a fetch.
- R9: A read of a different line address causes a fetch, and the new line replaces the old one. A later read of the old line fetches again.
- R10: Every accepted read reloads the staleness counter, including hits. A chain of hits each spaced N cycles apart keeps hitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; also clocks the staleness counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can take a read this cycle |
| req_addr | input | ADDR_W | Lane address of the read |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_data | output | LANE_W | Returned lane |
| mem_req_valid | output | 1 | Line fetch request to memory |
| mem_req_ready | input | 1 | Memory takes the fetch request |
| mem_req_addr | output | ADDR_W-OFF_W | Line address being fetched |
| mem_rsp_valid | input | 1 | Fetched line is present |
| mem_rsp_data | input | LINE_W | Fetched line |

## Verification
A read can arrive in the very cycle the staleness counter would run out. In that cycle, reload and expiry compete, and the matching tag must either win a hit or be overruled. The bench provokes this by spacing reads exactly N and then N+1 cycles after a preceding hit. It judges the outcome at the ports: the fetch count seen by the memory model, the one-cycle hit latency, and the returned lane value. The other collision is a refill returning while a new read waits. It is judged by `req_ready` staying low until the cycle after the line lands.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } rlc_state_e;
endpackage

// File: rtl/rlc_stale_timer.sv
module rlc_stale_timer #(
  parameter int unsigned CNT_W   = 9,
  parameter int unsigned TOUT    = 256,
  parameter bit          ENABLE  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic fresh,
  output logic expire
);
  localparam logic [CNT_W-1:0] LOAD_VAL = TOUT[CNT_W-1:0];

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = LOAD_VAL;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  generate
    if (ENABLE) begin : g_timed
      assign fresh  = (cnt_q != '0);
      assign expire = !load && (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});
    end else begin : g_hold
      assign fresh  = 1'b1;
      assign expire = 1'b0;
    end
  endgenerate

  // R6: the counter never exceeds the programmed window
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= int'(TOUT));

  // R10: a load always leaves the full window behind it
  assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> int'(cnt_q) == int'(TOUT));
endmodule

// File: rtl/rlc_line_store.sv
module rlc_line_store #(
  parameter int unsigned TAG_W  = 12,
  parameter int unsigned LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_data,
  input  logic              inval,
  output logic              valid,
  output logic [TAG_W-1:0]  tag,
  output logic [LINE_W-1:0] line
);
  logic              valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q;
  logic [LINE_W-1:0] line_q;

  always_comb begin
    valid_d = valid_q;
    if (fill)       valid_d = 1'b1;
    else if (inval) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_q  <= fill_tag;
      line_q <= fill_data;
    end
  end

  assign valid = valid_q;
  assign tag   = tag_q;
  assign line  = line_q;

  // R9: the line only becomes valid through a refill
  assert_valid_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(fill));
endmodule

// File: rtl/rlc_lane_sel.sv
module rlc_lane_sel #(
  parameter int unsigned LINE_W = 128,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned OFF_W  = 4
) (
  input  logic [LINE_W-1:0] line,
  input  logic [OFF_W-1:0]  off,
  output logic [LANE_W-1:0] lane
);
  localparam int unsigned LANES = LINE_W / LANE_W;

  logic [LANE_W-1:0] lanes [LANES];

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lanes[i] = line[i*LANE_W +: LANE_W];
    end
  endgenerate

  assign lane = lanes[off];
endmodule

// File: rtl/rd_line_cache.sv
module rd_line_cache
  import rlc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned LINE_W   = 128,
  parameter int unsigned LANE_W   = 8,
  parameter bit          TOUT_EN  = 1'b1,
  parameter int unsigned TOUT_W   = 9,
  parameter int unsigned TOUT_CYC = 256,
  localparam int unsigned LANES   = LINE_W / LANE_W,
  localparam int unsigned OFF_W   = $clog2(LANES),
  localparam int unsigned TAG_W   = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [LANE_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [TAG_W-1:0]  mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data
);
  rlc_state_e        state_q, state_d;
  logic [TAG_W-1:0]  pend_tag_q;
  logic [OFF_W-1:0]  pend_off_q;
  logic              pend_en;
  logic              rsp_valid_q, rsp_valid_d;
  logic [LANE_W-1:0] rsp_data_q, rsp_data_d;
  logic              rsp_data_en;

  logic              accept, hit, fill;
  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_off;
  logic              line_valid, fresh, expire;
  logic [TAG_W-1:0]  line_tag;
  logic [LINE_W-1:0] line_data;
  logic [LANE_W-1:0] hit_lane, fill_lane;

  assign req_tag   = req_addr[ADDR_W-1:OFF_W];
  assign req_off   = req_addr[OFF_W-1:0];
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign hit       = line_valid && fresh && (line_tag == req_tag);
  assign fill      = (state_q == ST_WAIT) && mem_rsp_valid;

  rlc_stale_timer #(
    .CNT_W (TOUT_W),
    .TOUT  (TOUT_CYC),
    .ENABLE(TOUT_EN)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .fresh (fresh),
    .expire(expire)
  );

  rlc_line_store #(
    .TAG_W (TAG_W),
    .LINE_W(LINE_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill     (fill),
    .fill_tag (pend_tag_q),
    .fill_data(mem_rsp_data),
    .inval    (expire),
    .valid    (line_valid),
    .tag      (line_tag),
    .line     (line_data)
  );

  rlc_lane_sel #(.LINE_W(LINE_W), .LANE_W(LANE_W), .OFF_W(OFF_W)) u_hit_sel (
    .line(line_data),
    .off (req_off),
    .lane(hit_lane)
  );

  rlc_lane_sel #(.LINE_W(LINE_W), .LANE_W(LANE_W), .OFF_W(OFF_W)) u_fill_sel (
    .line(mem_rsp_data),
    .off (pend_off_q),
    .lane(fill_lane)
  );

  always_comb begin
    state_d = state_q;
    pend_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && !hit) begin
          state_d = ST_ISSUE;
          pend_en = 1'b1;
        end
      end
      ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rsp_valid_d = (accept && hit) || fill;
    rsp_data_en = rsp_valid_d;
    rsp_data_d  = fill ? fill_lane : hit_lane;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_en) begin
      pend_tag_q <= req_tag;
      pend_off_q <= req_off;
    end
    if (rsp_data_en) rsp_data_q <= rsp_data_d;
  end

  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_req_addr  = pend_tag_q;
  assign rsp_valid     = rsp_valid_q;
  assign rsp_data      = rsp_data_q;

  // R2: a pending fetch holds its request and address until taken
  assert_mem_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R3: a missing read closes the request side on the next cycle
  assert_one_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit |=> !req_ready);

  // R4: a delivered line reopens the request side and answers
  assert_refill_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> rsp_valid && req_ready);

  // R5: a hit answers on the next cycle without touching memory
  assert_hit_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit |=> rsp_valid && !mem_req_valid);

  generate
    if (TOUT_EN && (TOUT_CYC == 0)) begin : g_nocache_chk
      // R7: with a zero window no read is ever answered the next cycle
      assert_no_cache_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !rsp_valid);
    end
  endgenerate
endmodule

// File: tb/rd_line_cache_tb_top.sv
module rd_line_cache_tb_top;
  localparam int AW = 16;
  localparam int LW = 128;
  localparam int DW = 8;
  localparam int TW = 12;
  localparam int WIN = 8;

  logic clk;
  logic rst_n;
  logic          req_valid     [3];
  logic          req_ready     [3];
  logic [AW-1:0] req_addr      [3];
  logic          rsp_valid     [3];
  logic [DW-1:0] rsp_data      [3];
  logic          mem_req_valid [3];
  logic          mem_req_ready [3];
  logic [TW-1:0] mem_req_addr  [3];
  logic          mem_rsp_valid [3];
  logic [LW-1:0] mem_rsp_data  [3];

  int            fetches [3];
  int            dly     [3];
  logic [TW-1:0] maddr   [3];
  int checks;
  int fails;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // timed window of WIN cycles
  rd_line_cache #(.TOUT_EN(1'b1), .TOUT_CYC(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_addr(req_addr[0]),
    .rsp_valid(rsp_valid[0]), .rsp_data(rsp_data[0]),
    .mem_req_valid(mem_req_valid[0]), .mem_req_ready(mem_req_ready[0]),
    .mem_req_addr(mem_req_addr[0]), .mem_rsp_valid(mem_rsp_valid[0]),
    .mem_rsp_data(mem_rsp_data[0]));

  // timeout disabled, window value ignored
  rd_line_cache #(.TOUT_EN(1'b0), .TOUT_CYC(4)) dut_keep_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_addr(req_addr[1]),
    .rsp_valid(rsp_valid[1]), .rsp_data(rsp_data[1]),
    .mem_req_valid(mem_req_valid[1]), .mem_req_ready(mem_req_ready[1]),
    .mem_req_addr(mem_req_addr[1]), .mem_rsp_valid(mem_rsp_valid[1]),
    .mem_rsp_data(mem_rsp_data[1]));

  // zero window: caching off
  rd_line_cache #(.TOUT_EN(1'b1), .TOUT_CYC(0)) dut_off_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[2]), .req_ready(req_ready[2]), .req_addr(req_addr[2]),
    .rsp_valid(rsp_valid[2]), .rsp_data(rsp_data[2]),
    .mem_req_valid(mem_req_valid[2]), .mem_req_ready(mem_req_ready[2]),
    .mem_req_addr(mem_req_addr[2]), .mem_rsp_valid(mem_rsp_valid[2]),
    .mem_rsp_data(mem_rsp_data[2]));

  function automatic logic [DW-1:0] exp_byte(input logic [AW-1:0] a);
    int line;
    int i;
    line = int'(a[AW-1:4]);
    i    = int'(a[3:0]);
    return 8'((line * 5 + i * 17 + 3) & 255);
  endfunction

  function automatic logic [LW-1:0] line_of(input logic [TW-1:0] t);
    logic [LW-1:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = exp_byte({t, 4'(i)});
    return v;
  endfunction

  // memory model: accepts a fetch, answers two cycles later
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 3; g++) begin
        dly[g] <= 0;
        fetches[g] <= 0;
        mem_rsp_valid[g] <= 1'b0;
        mem_rsp_data[g] <= '0;
        maddr[g] <= '0;
      end
    end else begin
      for (int g = 0; g < 3; g++) begin
        if (mem_req_valid[g] && mem_req_ready[g]) begin
          fetches[g] <= fetches[g] + 1;
          maddr[g] <= mem_req_addr[g];
          dly[g] <= 2;
        end else if (dly[g] != 0) begin
          dly[g] <= dly[g] - 1;
        end
        mem_rsp_valid[g] <= (dly[g] == 1);
        mem_rsp_data[g] <= line_of(maddr[g]);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // entered and left just after a falling edge
  task automatic do_read(input int g, input logic [AW-1:0] a, output logic [DW-1:0] d,
                         output bit fetched, output int lat, output bit rdy_after);
    int f0;
    f0 = fetches[g];
    req_addr[g] = a;
    req_valid[g] = 1'b1;
    while (!req_ready[g]) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid[g] = 1'b0;
    rdy_after = req_ready[g];
    lat = 1;
    while (!rsp_valid[g] && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    d = rsp_data[g];
    fetched = (fetches[g] != f0);
  endtask

  task automatic t_reset();
    for (int g = 0; g < 3; g++) begin
      chk(req_ready[g] == 1'b1, "R1 req_ready after reset", int'(req_ready[g]), 1);
      chk(rsp_valid[g] == 1'b0 && mem_req_valid[g] == 1'b0, "R1 outputs idle after reset",
          int'({rsp_valid[g], mem_req_valid[g]}), 0);
    end
  endtask

  task automatic t_first_miss();
    logic [DW-1:0] d; bit f; int lat; bit r;
    do_read(0, 16'h1235, d, f, lat, r);
    chk(f, "R1 first read fetches", int'(f), 1);
    chk(!r, "R3 ready low during fetch", int'(r), 0);
    chk(d == exp_byte(16'h1235), "R4 refill lane", int'(d), int'(exp_byte(16'h1235)));
    chk(req_ready[0] == 1'b1, "R3 ready back with response", int'(req_ready[0]), 1);
  endtask

  task automatic t_hit();
    logic [DW-1:0] d; bit f; int lat; bit r;
    do_read(0, 16'h123A, d, f, lat, r);
    chk(!f && lat == 1, "R5 hit no fetch latency1", lat + (f ? 100 : 0), 1);
    chk(d == exp_byte(16'h123A), "R5 hit lane 10", int'(d), int'(exp_byte(16'h123A)));
    do_read(0, 16'h1230, d, f, lat, r);
    chk(!f && d == exp_byte(16'h1230), "R5 hit lane 0", int'(d), int'(exp_byte(16'h1230)));
  endtask

  task automatic t_window();
    logic [DW-1:0] d; bit f; int lat; bit r;
    repeat (WIN - 1) @(negedge clk);
    do_read(0, 16'h123F, d, f, lat, r);
    chk(!f && lat == 1, "R6 read at gap N hits", int'(f), 0);
    chk(d == exp_byte(16'h123F), "R6 lane at gap N", int'(d), int'(exp_byte(16'h123F)));
    repeat (WIN - 1) @(negedge clk);
    do_read(0, 16'h1233, d, f, lat, r);
    chk(!f, "R10 reload keeps chain hitting", int'(f), 0);
    repeat (WIN) @(negedge clk);
    do_read(0, 16'h1234, d, f, lat, r);
    chk(f, "R6 read at gap N+1 refetches", int'(f), 1);
    chk(d == exp_byte(16'h1234), "R6 refetched lane", int'(d), int'(exp_byte(16'h1234)));
  endtask

  task automatic t_hold();
    int lat;
    mem_req_ready[0] = 1'b0;
    req_addr[0] = 16'h4567;
    req_valid[0] = 1'b1;
    while (!req_ready[0]) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid[0] = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(mem_req_valid[0] && mem_req_addr[0] == 12'h456, "R2 fetch held while stalled",
          int'({mem_req_valid[0], mem_req_addr[0]}), int'({1'b1, 12'h456}));
      @(negedge clk);
    end
    mem_req_ready[0] = 1'b1;
    lat = 0;
    while (!rsp_valid[0] && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    chk(rsp_data[0] == exp_byte(16'h4567), "R9 new line lane", int'(rsp_data[0]),
        int'(exp_byte(16'h4567)));
  endtask

  task automatic t_replace();
    logic [DW-1:0] d; bit f; int lat; bit r;
    do_read(0, 16'h1231, d, f, lat, r);
    chk(f, "R9 old line refetched after replace", int'(f), 1);
    chk(d == exp_byte(16'h1231), "R9 old line data", int'(d), int'(exp_byte(16'h1231)));
  endtask

  task automatic t_nocache();
    logic [DW-1:0] d; bit f; int lat; bit r;
    do_read(2, 16'h0105, d, f, lat, r);
    chk(f, "R7 first read fetches", int'(f), 1);
    do_read(2, 16'h0106, d, f, lat, r);
    chk(f, "R7 same line still fetches", int'(f), 1);
    chk(d == exp_byte(16'h0106), "R7 data", int'(d), int'(exp_byte(16'h0106)));
  endtask

  task automatic t_keep();
    logic [DW-1:0] d; bit f; int lat; bit r;
    do_read(1, 16'h0777, d, f, lat, r);
    chk(f, "R8 first read fetches", int'(f), 1);
    repeat (60) @(negedge clk);
    do_read(1, 16'h0770, d, f, lat, r);
    chk(!f && lat == 1, "R8 long gap still hits", int'(f), 0);
    chk(d == exp_byte(16'h0770), "R8 hit data", int'(d), int'(exp_byte(16'h0770)));
    do_read(1, 16'h0881, d, f, lat, r);
    chk(f, "R8 other line fetches", int'(f), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks = 0;
    fails = 0;
    for (int g = 0; g < 3; g++) begin
      req_valid[g] = 1'b0;
      req_addr[g] = '0;
      mem_req_ready[g] = 1'b1;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_miss();
    t_hit();
    t_window();
    t_hold();
    t_replace();
    t_nocache();
    t_keep();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule